// File: doc/BRIEF.md
# Three-Sample Timing-Speculative Pipeline Register

This block sits between two logic stages and lets the stage clock run faster than the worst-case path delay allows. It captures the stage result at three moments of each pipeline cycle. The first capture happens on the main clock edge. The other two happen after two fixed delay offsets. The first capture goes straight to the output as a speculative value. The two later captures act as referees. When they show that the speculative value was wrong, because the data arrived late or a transient hit, the register fixes its own output. It then raises a one-cycle error flag and holds the pipeline for a set number of recovery cycles.

The delayed clock phases are modelled as synchronous strobes. A free-running phase counter on a fast base clock produces them, with `PERIOD` base cycles making one pipeline cycle. The correction takes the bit-wise majority of the three captures and compares it with the value the register currently holds. So a transient that corrupts only one capture is outvoted, and a correct value is never flagged. The parameters must keep each offset at least as wide as the longest expected noise pulse. The stage's shortest path must cover the sum of both offsets, and its longest path must fit inside one period plus the first offset.

The recovery controller is a three-state machine. The states are RUN, FLAG and HOLD. In RUN the phase counter advances and the captures take place. RUN moves to FLAG on the judge tick when the majority differs from the held value (transition "mismatch"). FLAG is the single stall cycle that carries the error flag. FLAG returns to RUN when the recovery length is one (transition "short recovery"); otherwise it moves to HOLD (transition "extend"). HOLD keeps the stall asserted and leaves for RUN when its down-counter reaches zero (transition "recovered"). During FLAG and HOLD the phase counter is frozen.

Top module: `tspec_reg`

## Requirements
- R1: While `rst_n` is low, `q` is 0, and `err` and `stall` are 0.
- R2: The phase counter starts at 0 after reset. The edge at phase 0 loads `d_in` into `q`, so the new speculative value shows on `q` in the cycle after that edge.
- R3: The captures happen on the edges at phases 0, `PHI1` and `PHI1+PHI2`. The judgement is made on the edge at phase `PHI1+PHI2+1`.
- R4: When all three captures are equal and match `q`, `q` keeps its value and `err` and `stall` stay low.
- R5: When the two delayed captures agree with each other but differ from the first one, the judge edge loads their value into `q` and `err` is high for exactly one cycle.
- R6: When only the third capture differs from the other two, `q`, `err` and `stall` are unaffected.
- R7: When only the second capture differs from the other two, `q`, `err` and `stall` are unaffected.
- R8: Correction is per bit. Each bit of the corrected `q` is the majority of that bit across the three captures, and `err` is raised when any bit of that majority differs from `q`.
- R9: `stall` is high for exactly `N_RECOV` consecutive cycles, starting with the cycle in which `err` is high. The phase counter does not advance during those cycles, so the next phase-0 capture comes `N_RECOV` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; `PERIOD` cycles form one pipeline cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| d_in | input | W | Output of the preceding logic stage |
| q | output | W | Speculative value, corrected in place when needed |
| err | output | 1 | Stage error flag, one cycle per correction |
| stall | output | 1 | Pipeline hold request during recovery |

## Verification
The bench builds the block with `W=8`, `PERIOD=8`, `PHI1=2`, `PHI2=2` and `N_RECOV=3`. A short period puts many pipeline cycles, and so many capture patterns, into a brief run. Equal offsets put the judge tick at phase 5, which leaves two free phases before the next launch. A recovery length of three makes the machine pass through FLAG and then stay in HOLD for more than one cycle, so the stall length and the frozen phase are both observable. An 8-bit word allows patterns where different bits are outvoted by different captures in the same cycle.

// File: rtl/tspec_pkg.sv
package tspec_pkg;

    // number of capture instants per pipeline cycle
    localparam int NTAP = 3;

    // recovery controller states
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_FLAG = 2'd1,
        ST_HOLD = 2'd2
    } rec_state_t;

    // phase offset of capture instant i, counted from the main edge
    function automatic int tap_offset(input int i, input int phi1, input int phi2);
        int r;
        r = 0;
        if (i >= 1) r = r + phi1;
        if (i >= 2) r = r + phi2;
        return r;
    endfunction

endpackage

// File: rtl/tspec_phase_gen.sv
module tspec_phase_gen
    import tspec_pkg::*;
#(
    parameter int PERIOD = 8,
    parameter int PHI1   = 2,
    parameter int PHI2   = 2,
    localparam int CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1,
    localparam int JUDGE = PHI1 + PHI2 + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [CW-1:0]   phase,
    output logic [NTAP-1:0] strb,
    output logic            strb_judge
);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run) begin
            if (phase_q == CW'(PERIOD - 1))
                phase_q <= '0;
            else
                phase_q <= phase_q + CW'(1);
        end
    end

    assign phase = phase_q;

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int OFS = tap_offset(i, PHI1, PHI2);
        assign strb[i] = run && (phase_q == CW'(OFS));
    end

    assign strb_judge = run && (phase_q == CW'(JUDGE));

endmodule

// File: rtl/tspec_sample_bank.sv
module tspec_sample_bank
    import tspec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            d,
    input  logic [NTAP-1:0]         strb,
    output logic [NTAP-1:0][W-1:0]  smp
);

    for (genvar i = 0; i < NTAP; i++) begin : g_cap
        logic [W-1:0] cap_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cap_q <= '0;
            else if (strb[i])
                cap_q <= d;
        end
        assign smp[i] = cap_q;
    end

endmodule

// File: rtl/tspec_vote.sv
module tspec_vote
    import tspec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NTAP-1:0][W-1:0] smp,
    input  logic [W-1:0]           held,
    output logic [W-1:0]           corr,
    output logic                   mism
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign corr[b] = (smp[0][b] & smp[1][b]) |
                         (smp[0][b] & smp[2][b]) |
                         (smp[1][b] & smp[2][b]);
    end

    assign mism = (corr != held);

endmodule

// File: rtl/tspec_recover_fsm.sv
module tspec_recover_fsm
    import tspec_pkg::*;
#(
    parameter int N_RECOV = 3,
    localparam int RCW    = (N_RECOV > 1) ? $clog2(N_RECOV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic judge,
    input  logic mism,
    output logic err,
    output logic stall,
    output logic run
);

    rec_state_t     state_q, state_d;
    logic [RCW-1:0] hcnt_q, hcnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (judge && mism) begin
                    state_d = ST_FLAG;
                    hcnt_d  = RCW'(N_RECOV - 1);
                end
            end
            ST_FLAG, ST_HOLD: begin
                if (hcnt_q == '0) begin
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_HOLD;
                    hcnt_d  = hcnt_q - RCW'(1);
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        err   = 1'b0;
        stall = 1'b0;
        run   = 1'b0;
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            ST_FLAG: begin
                err   = 1'b1;
                stall = 1'b1;
            end
            ST_HOLD: stall = 1'b1;
            default: run = 1'b1;
        endcase
    end

endmodule

// File: rtl/tspec_reg.sv
module tspec_reg
    import tspec_pkg::*;
#(
    parameter int W       = 8,
    parameter int PERIOD  = 8,
    parameter int PHI1    = 2,
    parameter int PHI2    = 2,
    parameter int N_RECOV = 3,
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q,
    output logic         err,
    output logic         stall
);

    logic [CW-1:0]           phase;
    logic [NTAP-1:0]         strb;
    logic                    strb_judge;
    logic                    run;
    logic [NTAP-1:0][W-1:0]  smp;
    logic [W-1:0]            corr;
    logic                    mism;
    logic [W-1:0]            q_q;

    tspec_phase_gen #(.PERIOD(PERIOD), .PHI1(PHI1), .PHI2(PHI2)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run),
        .phase(phase), .strb(strb), .strb_judge(strb_judge)
    );

    tspec_sample_bank #(.W(W)) u_bank (
        .clk(clk), .rst_n(rst_n), .d(d_in), .strb(strb), .smp(smp)
    );

    tspec_vote #(.W(W)) u_vote (
        .smp(smp), .held(q_q), .corr(corr), .mism(mism)
    );

    tspec_recover_fsm #(.N_RECOV(N_RECOV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .judge(strb_judge), .mism(mism),
        .err(err), .stall(stall), .run(run)
    );

    // speculative launch on the main edge, local repair on the judge edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_q <= '0;
        else if (strb[0])
            q_q <= d_in;
        else if (strb_judge && mism)
            q_q <= corr;
    end

    assign q = q_q;

endmodule

// File: rtl/tspec_reg_chk.sv
module tspec_reg_chk #(
    parameter int W       = 8,
    parameter int N_RECOV = 3,
    parameter int CW      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  q,
    input logic          err,
    input logic          stall,
    input logic [CW-1:0] phase,
    input logic          strb_main,
    input logic          strb_judge
);

    localparam int SW = $clog2(N_RECOV + 2);
    logic [SW-1:0] stall_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stall_run <= '0;
        else if (stall)
            stall_run <= stall_run + SW'(1);
        else
            stall_run <= '0;
    end

    // R5
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R5
    err_changes_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (q != $past(q)));

    // R9
    err_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> stall);

    // R9
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_run < SW'(N_RECOV)));

    // R9
    phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !err) |-> $stable(phase));

    // R2
    q_moves_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> $past(strb_main || strb_judge));

endmodule

bind tspec_reg tspec_reg_chk #(.W(W), .N_RECOV(N_RECOV), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .q(q), .err(err), .stall(stall),
    .phase(phase), .strb_main(strb[0]), .strb_judge(strb_judge)
);

// File: tb/tspec_reg_tb.sv
module tspec_reg_tb;

    localparam int W       = 8;
    localparam int PERIOD  = 8;
    localparam int PHI1    = 2;
    localparam int PHI2    = 2;
    localparam int N_RECOV = 3;
    localparam int JUDGE   = PHI1 + PHI2 + 1;

    typedef struct {
        bit           is_judge;
        logic [W-1:0] q_exp;
        bit           err_exp;
        int           req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q;
    logic         err;
    logic         stall;

    int    n_tests = 0;
    int    n_fail  = 0;
    item_t sb[$];
    logic [W-1:0] q_model = '0;
    int    stall_left = 0;
    bit    want_release = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    tspec_reg #(.W(W), .PERIOD(PERIOD), .PHI1(PHI1), .PHI2(PHI2), .N_RECOV(N_RECOV)) u_dut (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .q(q), .err(err), .stall(stall)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one pipeline cycle: first/second/third capture values a, b, c
    task automatic pcycle(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input int req);
        for (int t = 0; t < PERIOD; t++) begin
            d_in = (t < PHI1) ? a : ((t < PHI1 + PHI2) ? b : c);
            @(posedge clk);
            if (t == 0) begin
                q_model = a;
                sb.push_back('{is_judge: 0, q_exp: a, err_exp: 0, req: 2});
            end
            if (t == JUDGE) begin
                logic [W-1:0] maj;
                bit e;
                maj = (a & b) | (a & c) | (b & c);
                e = (maj != q_model);
                q_model = maj;
                sb.push_back('{is_judge: 1, q_exp: maj, err_exp: e, req: req});
                if (e) repeat (N_RECOV) @(posedge clk);
            end
            @(negedge clk);
        end
    endtask

    // monitor: compare at the falling edge after each scored event
    initial begin
        forever begin
            @(negedge clk);
            if (stall_left > 0) begin
                check("R9 stall held", stall, 1'b1);
                check("R5 err one cycle", err, 1'b0);
                stall_left--;
            end else if (want_release) begin
                check("R9 stall released", stall, 1'b0);
                want_release = 0;
            end
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check($sformatf("R%0d q", it.req), q, it.q_exp);
                if (it.is_judge) begin
                    check($sformatf("R%0d err", it.req), err, it.err_exp);
                    check($sformatf("R%0d stall", it.req), stall, it.err_exp);
                    if (it.err_exp) begin
                        stall_left = N_RECOV - 1;
                        want_release = 1;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 q", q, '0);
        check("R1 err", {7'b0, err}, '0);
        check("R1 stall", {7'b0, stall}, '0);
        rst_n = 1'b1;
        // R2 R3 R4: clean cycles, several values
        pcycle(8'hA5, 8'hA5, 8'hA5, 4);
        pcycle(8'h3C, 8'h3C, 8'h3C, 4);
        pcycle(8'h00, 8'h00, 8'h00, 4);
        // R5: late data, delayed captures agree
        pcycle(8'h11, 8'h7E, 8'h7E, 5);
        pcycle(8'hFF, 8'h80, 8'h80, 5);
        // R6: late transient on third capture only
        pcycle(8'h42, 8'h42, 8'hBD, 6);
        // R7: transient on middle capture only
        pcycle(8'h99, 8'h66, 8'h99, 7);
        // R8: mixed bits, majority per bit
        pcycle(8'b1100_0000, 8'b1010_1010, 8'b0110_0101, 8);
        pcycle(8'hF0, 8'h0F, 8'hFF, 8);
        // R9: back-to-back corrections then a clean cycle
        pcycle(8'h01, 8'h02, 8'h02, 9);
        pcycle(8'h04, 8'h08, 8'h08, 9);
        pcycle(8'h5A, 8'h5A, 8'h5A, 9);
        repeat (4) @(negedge clk);
        check("R4 quiet end", {7'b0, stall}, '0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule